// File: doc/BRIEF.md
# Message-Signalled Interrupt File

This block keeps the pending and enable bits for every message-signalled interrupt identity that one hart can receive. Its size is set by a parameter (128 identities by default, identity 0 included but never usable). Devices deliver an interrupt by writing its identity number into a small injection window. The window has a little-endian word and a big-endian word; a value written to the big-endian word has its bytes reversed before it is used.

Software reaches the state through an indirect register port. Each access gives a select value, and that value picks the delivery switch, the priority threshold, the claim register, or one word of the pending or enable arrays. Every write is masked, and every access returns the value the register held before the access. The claim register reports the winning interrupt: the lowest-numbered identity that is both pending and enabled, limited by the threshold when the threshold is nonzero. Any write to the claim register retires the winning interrupt. A single registered output asks the hart to take an external interrupt.

Top module: `msi_irq_file`

## Requirements
- R1: A synchronous active-high reset clears every pending bit, enable bit, the threshold and the delivery switch. It also drops `ext_irq`, `rsp_valid` and `inj_rsp_valid`.
- R2: Identity 0 is inert. Bit 0 of pending word 0 and bit 0 of enable word 0 always read 0 and ignore writes. An injected value of 0 is discarded.
- R3: A 32-bit write at injection offset 0x0 whose value v satisfies 0 < v < NUM_IDS sets pending bit v one clock after the write. Any value at or above NUM_IDS is discarded.
- R4: At injection offset 0x4 the written word is byte-reversed before the R3 rule is applied.
- R5: An injection access whose size code is not 2 (4 bytes), or whose address is not word-aligned, changes nothing and returns `inj_rsp_fault`=1 one clock later. Injection reads return 0 and change nothing. Aligned writes to any other offset are ignored without a fault.
- R6: A register access is answered one clock after it is presented, on `rsp_valid`/`rsp_rdata`/`rsp_status`. The answer carries the value the register held before the access. A write changes only the bits set in `req_wmask`.
- R7: The delivery switch stores only bit 0. The threshold stores only its low log2(NUM_IDS) bits.
- R8: Select values: 0x70 is the delivery switch, 0x72 the threshold, 0x76 the claim register, 0x80+n pending index n, and 0xC0+n enable index n. With 64-bit words, index n reaches word n/2 and must be even. An odd index, or a word beyond NUM_IDS/WORD_W, gives status 1 (illegal). Any other select gives status 2 (absent). Status 0 is success. An erroring access reads 0 and changes nothing.
- R9: The winning interrupt is the lowest identity whose pending and enable bits are both set. When the threshold t is nonzero, only identities below t compete.
- R10: The claim register reads (id << 16) | id for the winning identity, and reads 0 when no identity wins.
- R11: Any write to the claim register, whatever its data and mask, clears the pending bit of the identity that wins at that moment. With no winner it changes nothing.
- R12: `ext_irq` is registered. One clock after the state it depends on, it equals the delivery switch ANDed with "a winner exists".
- R13: When an injection and a register write that clears the same pending bit land in the same clock, the injection wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always 1; a request is taken every clock |
| req_sel | input | 8 | Register select value |
| req_we | input | 1 | Request is a write |
| req_wdata | input | WORD_W | Write data |
| req_wmask | input | WORD_W | Bits of the register that the write may change |
| rsp_valid | output | 1 | Response valid, one clock after the request |
| rsp_rdata | output | WORD_W | Register value before the access |
| rsp_status | output | 2 | 0 ok, 1 illegal index, 2 absent select |
| inj_valid | input | 1 | Injection window access |
| inj_write | input | 1 | Injection access is a write |
| inj_addr | input | OFS_W | Byte offset in the injection window |
| inj_size | input | 2 | log2 of access size in bytes |
| inj_wdata | input | 32 | Injected identity word |
| inj_rsp_valid | output | 1 | Injection response valid |
| inj_rsp_rdata | output | 32 | Injection read data (always 0) |
| inj_rsp_fault | output | 1 | Access had a bad size or alignment |
| ext_irq | output | 1 | External interrupt request to the hart |

## Verification
Every identity from 0 to a few past the top is injected in turn, alternating between the little-endian and big-endian words, and then claimed and retired. This separates correct range checking and byte reversal from off-by-one limits and swapped lanes. The threshold is swept over all 128 values while a fixed set of four identities is pending, and the claim value is compared with a computed lowest-eligible identity. That sweep exposes strict-versus-inclusive comparison errors and the zero-means-off rule. Further directed patterns cover masked writes, bad select indices, faulting injections, and an injection that collides with a clearing write in the same clock, to show which side takes precedence.

// File: rtl/msi_file_pkg.sv
`timescale 1ns/1ps
package msi_file_pkg;

  localparam logic [7:0] SEL_DELIVER   = 8'h70;
  localparam logic [7:0] SEL_THRESH    = 8'h72;
  localparam logic [7:0] SEL_CLAIM     = 8'h76;

  typedef enum logic [1:0] {
    ACC_OK      = 2'd0,
    ACC_ILLEGAL = 2'd1,
    ACC_ABSENT  = 2'd2
  } acc_status_e;

  typedef enum logic [2:0] {
    T_DELIVER,
    T_THRESH,
    T_CLAIM,
    T_PEND,
    T_EN,
    T_NONE
  } reg_target_e;

  typedef struct packed {
    reg_target_e target;
    logic [5:0]  index;
  } sel_decode_t;

  // Map a select value to a register class and the array index it carries.
  function automatic sel_decode_t decode_sel(input logic [7:0] sel);
    sel_decode_t r;
    r.index  = sel[5:0];
    r.target = T_NONE;
    if (sel[7:6] == 2'b10)      r.target = T_PEND;
    else if (sel[7:6] == 2'b11) r.target = T_EN;
    else if (sel == SEL_DELIVER) r.target = T_DELIVER;
    else if (sel == SEL_THRESH)  r.target = T_THRESH;
    else if (sel == SEL_CLAIM)   r.target = T_CLAIM;
    return r;
  endfunction

  function automatic logic [31:0] swap_bytes(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

endpackage

// File: rtl/msi_sel_check.sv
`timescale 1ns/1ps
module msi_sel_check
  import msi_file_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 2,
  parameter int WIDX_W    = 1
) (
  input  logic [7:0]        sel,
  output reg_target_e       target,
  output logic [WIDX_W-1:0] word,
  output acc_status_e       status
);

  sel_decode_t dec;
  logic        odd_bad;
  logic [5:0]  wsel;

  assign dec = decode_sel(sel);

  generate
    if (WORD_W == 64) begin : g_even_only
      assign odd_bad = dec.index[0];
      assign wsel    = {1'b0, dec.index[5:1]};
    end else begin : g_dense
      assign odd_bad = 1'b0;
      assign wsel    = dec.index;
    end
  endgenerate

  always_comb begin
    target = dec.target;
    status = ACC_OK;
    word   = '0;
    if (dec.target == T_NONE) begin
      status = ACC_ABSENT;
    end else if (dec.target == T_PEND || dec.target == T_EN) begin
      if (odd_bad || int'(wsel) >= NUM_WORDS) status = ACC_ILLEGAL;
      else word = wsel[WIDX_W-1:0];
    end
  end

endmodule

// File: rtl/msi_inj_decode.sv
`timescale 1ns/1ps
module msi_inj_decode
  import msi_file_pkg::*;
#(
  parameter int NUM_IDS = 128,
  parameter int ID_W    = 7,
  parameter int OFS_W   = 12
) (
  input  logic             valid,
  input  logic             write,
  input  logic [OFS_W-1:0] addr,
  input  logic [1:0]       size,
  input  logic [31:0]      wdata,
  output logic             set_v,
  output logic [ID_W-1:0]  set_id,
  output logic             fault
);

  logic [31:0] value;
  logic        hit;

  always_comb begin
    fault  = valid && (size != 2'd2 || addr[1:0] != 2'b00);
    // offset 0x4 carries the big-endian copy of the word
    value  = addr[2] ? swap_bytes(wdata) : wdata;
    hit    = valid && write && !fault && (addr[OFS_W-1:3] == '0);
    set_v  = hit && (value != 32'd0) && (value < 32'(NUM_IDS));
    set_id = value[ID_W-1:0];
  end

endmodule

// File: rtl/msi_top_pick.sv
`timescale 1ns/1ps
module msi_top_pick #(
  parameter int NUM_IDS = 128,
  parameter int ID_W    = 7
) (
  input  logic [NUM_IDS-1:0] elig,
  output logic               found,
  output logic [ID_W-1:0]    id
);

  // Scan downward so the lowest eligible identity is assigned last.
  always_comb begin
    found = 1'b0;
    id    = '0;
    for (int i = NUM_IDS - 1; i >= 1; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        id    = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/msi_irq_file.sv
`timescale 1ns/1ps
module msi_irq_file
  import msi_file_pkg::*;
#(
  parameter int NUM_IDS = 128,
  parameter int WORD_W  = 64,
  parameter int OFS_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_sel,
  input  logic              req_we,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [WORD_W-1:0] req_wmask,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_status,
  input  logic              inj_valid,
  input  logic              inj_write,
  input  logic [OFS_W-1:0]  inj_addr,
  input  logic [1:0]        inj_size,
  input  logic [31:0]       inj_wdata,
  output logic              inj_rsp_valid,
  output logic [31:0]       inj_rsp_rdata,
  output logic              inj_rsp_fault,
  output logic              ext_irq
);

  localparam int ID_W        = $clog2(NUM_IDS);
  localparam int THR_W       = ID_W;
  localparam int NUM_WORDS   = NUM_IDS / WORD_W;
  localparam int WIDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int CLAIM_SHIFT = 16;

  logic [NUM_IDS-1:0] pend_q, pend_d, en_q, en_d;
  logic               deliv_q, deliv_d;
  logic [THR_W-1:0]   thr_q, thr_d;

  logic [NUM_IDS-1:0] thr_mask, elig;
  logic               top_found;
  logic [ID_W-1:0]    top_id;
  logic [WORD_W-1:0]  claim_word;

  reg_target_e        sel_target;
  logic [WIDX_W-1:0]  sel_word;
  acc_status_e        sel_status;
  logic [ID_W-1:0]    wbase;
  logic [WORD_W-1:0]  wmask_eff;
  logic [WORD_W-1:0]  rd_val;
  logic               wr_ok;

  logic               inj_set_v;
  logic [ID_W-1:0]    inj_set_id;
  logic               inj_fault;

  assign req_ready = 1'b1;

  msi_sel_check #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W)
  ) u_sel (
    .sel(req_sel), .target(sel_target), .word(sel_word), .status(sel_status)
  );

  msi_inj_decode #(
    .NUM_IDS(NUM_IDS), .ID_W(ID_W), .OFS_W(OFS_W)
  ) u_inj (
    .valid(inj_valid), .write(inj_write), .addr(inj_addr), .size(inj_size),
    .wdata(inj_wdata), .set_v(inj_set_v), .set_id(inj_set_id), .fault(inj_fault)
  );

  // Eligibility: a nonzero threshold admits only identities strictly below it.
  generate
    for (genvar g = 0; g < NUM_IDS; g++) begin : g_thr
      assign thr_mask[g] = (thr_q == '0) || (THR_W'(g) < thr_q);
    end
  endgenerate

  assign elig = pend_q & en_q & thr_mask;

  msi_top_pick #(
    .NUM_IDS(NUM_IDS), .ID_W(ID_W)
  ) u_pick (
    .elig(elig), .found(top_found), .id(top_id)
  );

  assign claim_word = top_found ?
    ((WORD_W'(top_id) << CLAIM_SHIFT) | WORD_W'(top_id)) : '0;

  assign wbase     = ID_W'(int'(sel_word) * WORD_W);
  // bit 0 of word 0 stands for identity 0 and is never writable
  assign wmask_eff = (sel_word == '0) ? (req_wmask & ~WORD_W'(1)) : req_wmask;
  assign wr_ok     = req_valid && req_we && (sel_status == ACC_OK);

  always_comb begin
    case (sel_target)
      T_DELIVER: rd_val = WORD_W'(deliv_q);
      T_THRESH:  rd_val = WORD_W'(thr_q);
      T_CLAIM:   rd_val = claim_word;
      T_PEND:    rd_val = pend_q[wbase +: WORD_W];
      T_EN:      rd_val = en_q[wbase +: WORD_W];
      default:   rd_val = '0;
    endcase
  end

  always_comb begin
    pend_d  = pend_q;
    en_d    = en_q;
    deliv_d = deliv_q;
    thr_d   = thr_q;
    if (wr_ok) begin
      case (sel_target)
        T_DELIVER: deliv_d = (deliv_q & ~req_wmask[0]) | (req_wdata[0] & req_wmask[0]);
        T_THRESH:  thr_d = (thr_q & ~req_wmask[THR_W-1:0]) |
                           (req_wdata[THR_W-1:0] & req_wmask[THR_W-1:0]);
        T_CLAIM:   if (top_found) pend_d[top_id] = 1'b0;
        T_PEND:    pend_d[wbase +: WORD_W] = (pend_q[wbase +: WORD_W] & ~wmask_eff) |
                                             (req_wdata & wmask_eff);
        T_EN:      en_d[wbase +: WORD_W] = (en_q[wbase +: WORD_W] & ~wmask_eff) |
                                           (req_wdata & wmask_eff);
        default: ;
      endcase
    end
    // injection applied last: it overrides a clear in the same clock
    if (inj_set_v) pend_d[inj_set_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q        <= '0;
      en_q          <= '0;
      deliv_q       <= 1'b0;
      thr_q         <= '0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_status    <= ACC_OK;
      inj_rsp_valid <= 1'b0;
      inj_rsp_rdata <= '0;
      inj_rsp_fault <= 1'b0;
      ext_irq       <= 1'b0;
    end else begin
      pend_q        <= pend_d;
      en_q          <= en_d;
      deliv_q       <= deliv_d;
      thr_q         <= thr_d;
      rsp_valid     <= req_valid;
      rsp_status    <= req_valid ? sel_status : ACC_OK;
      rsp_rdata     <= (req_valid && sel_status == ACC_OK) ? rd_val : '0;
      inj_rsp_valid <= inj_valid;
      inj_rsp_rdata <= '0;
      inj_rsp_fault <= inj_fault;
      ext_irq       <= deliv_q && top_found;
    end
  end

endmodule

// File: rtl/msi_irq_file_chk.sv
`timescale 1ns/1ps
module msi_irq_file_chk
  import msi_file_pkg::*;
#(
  parameter int NUM_IDS = 128,
  parameter int ID_W    = 7,
  parameter int THR_W   = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_we,
  input logic [7:0]         req_sel,
  input logic               rsp_valid,
  input logic [1:0]         sel_status,
  input logic [NUM_IDS-1:0] pend_q,
  input logic [NUM_IDS-1:0] en_q,
  input logic               deliv_q,
  input logic [THR_W-1:0]   thr_q,
  input logic               top_found,
  input logic [ID_W-1:0]    top_id,
  input logic               inj_set_v,
  input logic [ID_W-1:0]    inj_set_id,
  input logic               ext_irq
);

  assert_id0_inert_R2: assert property (@(posedge clk) disable iff (rst)
    !pend_q[0] && !en_q[0]);

  assert_irq_follows_R12: assert property (@(posedge clk) disable iff (rst)
    ext_irq == $past(deliv_q && top_found));

  assert_rsp_next_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid));

  assert_top_eligible_R9: assert property (@(posedge clk) disable iff (rst)
    top_found |-> (pend_q[top_id] && en_q[top_id] && top_id != '0));

  assert_top_below_thr_R9: assert property (@(posedge clk) disable iff (rst)
    (top_found && thr_q != '0) |-> (ID_W'(top_id) < ID_W'(thr_q)));

  assert_inject_sets_R3: assert property (@(posedge clk) disable iff (rst)
    inj_set_v |=> pend_q[$past(inj_set_id)]);

  assert_claim_clears_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && req_sel == SEL_CLAIM && top_found &&
     !(inj_set_v && inj_set_id == top_id)) |=> !pend_q[$past(top_id)]);

  assert_bad_sel_no_change_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sel_status != 2'd0) |=>
      ($stable(en_q) && $stable(deliv_q) && $stable(thr_q)));

endmodule

bind msi_irq_file msi_irq_file_chk #(
  .NUM_IDS(NUM_IDS), .ID_W(ID_W), .THR_W(THR_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
  .req_sel(req_sel), .rsp_valid(rsp_valid), .sel_status(sel_status),
  .pend_q(pend_q), .en_q(en_q), .deliv_q(deliv_q), .thr_q(thr_q),
  .top_found(top_found), .top_id(top_id), .inj_set_v(inj_set_v),
  .inj_set_id(inj_set_id), .ext_irq(ext_irq)
);

// File: tb/test_msi_irq_file.sv
`timescale 1ns/1ps
module test_msi_irq_file;
  localparam int NI = 128;
  localparam int WW = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic          req_valid, req_ready, req_we;
  logic [7:0]    req_sel;
  logic [WW-1:0] req_wdata, req_wmask;
  logic          rsp_valid;
  logic [WW-1:0] rsp_rdata;
  logic [1:0]    rsp_status;
  logic          inj_valid, inj_write;
  logic [11:0]   inj_addr;
  logic [1:0]    inj_size;
  logic [31:0]   inj_wdata;
  logic          inj_rsp_valid, inj_rsp_fault;
  logic [31:0]   inj_rsp_rdata;
  logic          ext_irq;

  msi_irq_file #(.NUM_IDS(NI), .WORD_W(WW), .OFS_W(12)) i_msi_irq_file (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel), .req_we(req_we),
    .req_wdata(req_wdata), .req_wmask(req_wmask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
    .inj_valid(inj_valid), .inj_write(inj_write), .inj_addr(inj_addr),
    .inj_size(inj_size), .inj_wdata(inj_wdata),
    .inj_rsp_valid(inj_rsp_valid), .inj_rsp_rdata(inj_rsp_rdata),
    .inj_rsp_fault(inj_rsp_fault), .ext_irq(ext_irq)
  );

  int checks = 0;
  int fails  = 0;
  logic [WW-1:0] rd;
  logic [1:0]    st;
  logic          flt;
  logic [31:0]   ird;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] claim_of(input int id);
    if (id <= 0 || id >= NI) return 64'd0;
    return (64'(id) << 16) | 64'(id);
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic reg_acc(input logic [7:0] sel, input logic we, input logic [63:0] wd,
                         input logic [63:0] wm, output logic [63:0] r, output logic [1:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_we = we; req_wdata = wd; req_wmask = wm;
    @(posedge clk); #1;
    r = rsp_rdata; s = rsp_status;
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic inject(input logic [11:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] d, output logic f, output logic [31:0] r);
    @(negedge clk);
    inj_valid = 1'b1; inj_addr = a; inj_size = sz; inj_write = wr; inj_wdata = d;
    @(posedge clk); #1;
    f = inj_rsp_fault; r = inj_rsp_rdata;
    inj_valid = 1'b0; inj_write = 1'b0;
  endtask

  task automatic both(input logic [7:0] sel, input logic [63:0] wd, input logic [63:0] wm,
                      input logic [31:0] id);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_we = 1'b1; req_wdata = wd; req_wmask = wm;
    inj_valid = 1'b1; inj_addr = 12'h0; inj_size = 2'd2; inj_write = 1'b1; inj_wdata = id;
    @(posedge clk); #1;
    req_valid = 1'b0; req_we = 1'b0; inj_valid = 1'b0; inj_write = 1'b0;
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    req_valid = 0; req_we = 0; req_sel = 0; req_wdata = 0; req_wmask = 0;
    inj_valid = 0; inj_write = 0; inj_addr = 0; inj_size = 0; inj_wdata = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 ext_irq", 64'(ext_irq), 64'd0);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    reg_acc(8'h70, 0, 0, 0, rd, st); check("R1 deliver", rd, 64'd0);
    check("R6 rsp_valid", 64'(rsp_valid), 64'd1);
    reg_acc(8'h72, 0, 0, 0, rd, st); check("R1 thresh", rd, 64'd0);
    reg_acc(8'h80, 0, 0, 0, rd, st); check("R1 pend0", rd, 64'd0);
    reg_acc(8'h82, 0, 0, 0, rd, st); check("R1 pend1", rd, 64'd0);
    reg_acc(8'hC0, 0, 0, 0, rd, st); check("R1 en0", rd, 64'd0);
    reg_acc(8'hC2, 0, 0, 0, rd, st); check("R1 en1", rd, 64'd0);
    reg_acc(8'h76, 0, 0, 0, rd, st); check("R10 claim empty", rd, 64'd0);
    @(posedge clk); #1; check("R6 rsp_valid drop", 64'(rsp_valid), 64'd0);

    // R2 / R6 enable words
    reg_acc(8'hC0, 1, '1, '1, rd, st); check("R6 old value", rd, 64'd0);
    reg_acc(8'hC0, 0, 0, 0, rd, st); check("R2 en0 bit0", rd, 64'hFFFF_FFFF_FFFF_FFFE);
    reg_acc(8'hC2, 1, '1, '1, rd, st);
    reg_acc(8'hC2, 0, 0, 0, rd, st); check("R6 en1", rd, '1);
    reg_acc(8'h80, 1, '1, '1, rd, st);
    reg_acc(8'h80, 0, 0, 0, rd, st); check("R2 pend0 bit0", rd, 64'hFFFF_FFFF_FFFF_FFFE);
    reg_acc(8'h80, 1, 0, '1, rd, st); check("R6 old pend0", rd, 64'hFFFF_FFFF_FFFF_FFFE);
    reg_acc(8'h82, 1, 64'hFFFF, 64'h00F0, rd, st);
    reg_acc(8'h82, 1, 0, '1, rd, st); check("R6 masked", rd, 64'h00F0);
    reg_acc(8'h82, 0, 0, 0, rd, st); check("R6 cleared", rd, 64'd0);

    // R7 field widths
    reg_acc(8'h70, 1, '1, '1, rd, st);
    reg_acc(8'h70, 1, 0, 64'h1, rd, st); check("R7 deliver bit0", rd, 64'd1);
    reg_acc(8'h72, 1, 64'hFFFF, '1, rd, st);
    reg_acc(8'h72, 1, 0, 64'h0, rd, st); check("R7 thresh width", rd, 64'h7F);
    reg_acc(8'h72, 1, 0, '1, rd, st); check("R7 thresh kept", rd, 64'h7F);

    // R3 R4 R10 R11 identity sweep
    for (int id = 0; id < NI + 4; id++) begin
      logic [31:0] d;
      d = (id % 2 == 1) ? bswap(32'(id)) : 32'(id);
      inject((id % 2 == 1) ? 12'h4 : 12'h0, 2'd2, 1'b1, d, flt, ird);
      reg_acc(8'h76, 0, 0, 0, rd, st);
      check((id % 2 == 1) ? "R4 swapped inject" : "R3 inject", rd, claim_of(id));
      reg_acc(8'h76, 1, 64'hDEAD, 64'h0, rd, st);
      check("R11 claim write old", rd, claim_of(id));
      reg_acc(8'h76, 0, 0, 0, rd, st);
      check("R11 retired", rd, 64'd0);
    end

    // R5 injection faults and reads
    inject(12'h0, 2'd1, 1'b1, 32'd3, flt, ird); check("R5 size fault", 64'(flt), 64'd1);
    inject(12'h2, 2'd2, 1'b1, 32'd3, flt, ird); check("R5 align fault", 64'(flt), 64'd1);
    inject(12'h0, 2'd2, 1'b0, 32'd3, flt, ird); check("R5 read zero", 64'(ird), 64'd0);
    check("R5 read no fault", 64'(flt), 64'd0);
    inject(12'h8, 2'd2, 1'b1, 32'd3, flt, ird); check("R5 other offset", 64'(flt), 64'd0);
    reg_acc(8'h76, 0, 0, 0, rd, st); check("R5 nothing set", rd, 64'd0);

    // R9 threshold sweep with {5,17,64,100} pending
    inject(12'h0, 2'd2, 1'b1, 32'd100, flt, ird);
    inject(12'h0, 2'd2, 1'b1, 32'd64, flt, ird);
    inject(12'h0, 2'd2, 1'b1, 32'd17, flt, ird);
    inject(12'h0, 2'd2, 1'b1, 32'd5, flt, ird);
    for (int t = 0; t < NI; t++) begin
      int e;
      e = 0;
      if (t == 0 || 5 < t) e = 5;
      reg_acc(8'h72, 1, 64'(t), '1, rd, st);
      reg_acc(8'h76, 0, 0, 0, rd, st);
      check("R9 threshold", rd, claim_of(e));
    end
    reg_acc(8'h72, 1, 0, '1, rd, st);

    // R12 external interrupt
    @(posedge clk); #1; check("R12 deliver off", 64'(ext_irq), 64'd0);
    reg_acc(8'h70, 1, 64'd1, 64'd1, rd, st);
    check("R12 one-cycle lag", 64'(ext_irq), 64'd0);
    @(posedge clk); #1; check("R12 asserted", 64'(ext_irq), 64'd1);
    reg_acc(8'h72, 1, 64'd5, '1, rd, st);
    @(posedge clk); #1; check("R12 thresh gates", 64'(ext_irq), 64'd0);
    reg_acc(8'h72, 1, 64'd0, '1, rd, st);
    @(posedge clk); #1; check("R12 back on", 64'(ext_irq), 64'd1);
    reg_acc(8'h76, 1, 0, 0, rd, st); check("R9 order 1", rd, claim_of(5));
    reg_acc(8'h76, 1, 0, 0, rd, st); check("R9 order 2", rd, claim_of(17));
    reg_acc(8'h76, 1, 0, 0, rd, st); check("R9 order 3", rd, claim_of(64));
    reg_acc(8'h76, 1, 0, 0, rd, st); check("R9 order 4", rd, claim_of(100));
    @(posedge clk); #1; check("R12 drained", 64'(ext_irq), 64'd0);

    // R8 select errors
    reg_acc(8'hC1, 1, 0, '1, rd, st); check("R8 odd index", 64'(st), 64'd1);
    check("R8 err rdata", rd, 64'd0);
    reg_acc(8'hC4, 1, 0, '1, rd, st); check("R8 word range", 64'(st), 64'd1);
    reg_acc(8'h00, 1, 0, '1, rd, st); check("R8 absent 00", 64'(st), 64'd2);
    reg_acc(8'h71, 1, 0, '1, rd, st); check("R8 absent 71", 64'(st), 64'd2);
    reg_acc(8'hC0, 0, 0, 0, rd, st); check("R8 en unchanged", rd, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R8 ok status", 64'(st), 64'd0);

    // R13 collisions
    inject(12'h0, 2'd2, 1'b1, 32'd9, flt, ird);
    both(8'h76, 0, 0, 32'd9);
    reg_acc(8'h76, 0, 0, 0, rd, st); check("R13 claim vs inject", rd, claim_of(9));
    both(8'h80, 0, '1, 32'd9);
    reg_acc(8'h80, 0, 0, 0, rd, st); check("R13 clear vs inject", rd, 64'h200);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule